// File: doc/BRIEF.md
# Weakly Ordered Store Buffer with Global Sync

A set of per-core store buffers sitting between processor cores and a shared banked memory, together with one shared synchronization arbiter. Each core hands stores to its buffer, which holds up to eight of them. The buffer then writes them to memory in whatever order the banks allow. An entry whose bank is free may overtake an older entry whose bank is stalled. The one exception is two stores to the same word: they always reach memory oldest first, so the word ends up holding the last value the core stored.

A core marks an epoch boundary by pulsing a sync request. Its buffer then refuses new stores and waits until every accepted store has been acknowledged by memory. It then asks the shared round-robin arbiter for a grant. Once granted, it pulses sync-done to the core for one cycle and opens again. The arbiter grants one core at a time, so all syncs fall into a single total order. Every store accepted after a sync therefore reaches memory after every store accepted before it.

Top module: `wsb_store_sys`

## Requirements
- R1: After reset every core's store ready is high, and no memory request, sync grant or sync-done is asserted.
- R2: A core's buffer accepts up to 8 stores while memory makes no progress. Its store ready then drops, and the other cores' ready is unaffected.
- R3: Of the entries eligible to write, the buffer issues the one with the lowest slot index. An entry is eligible if its bank is not busy and no older entry targets the same address. The bank is the address modulo the bank count (4 banks: address bits 1:0). A younger store to a free bank therefore overtakes an older store to a busy bank.
- R4: Stores from one core to the same address reach memory in acceptance order, whatever slots they occupy. The final memory word equals the last value stored to it.
- R5: A memory request holds its address and data stable until acknowledged (request and ack high at a clock edge). Each core has at most one write outstanding.
- R6: Store ready is low from the cycle after an accepted sync request until sync-done. Sync-done is not asserted until every store accepted before the request has been acknowledged.
- R7: No store accepted after a sync reaches memory before any store accepted before that sync.
- R8: The sync arbiter grants at most one core per cycle, and only a core that is requesting. Search starts at the core after the last one granted, so two cores waiting together are served in rotation. Each core's sync-done follows its grant by exactly one cycle.
- R9: Each accepted sync produces exactly one single-cycle sync-done. A sync request that arrives while that core's sync is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_valid_i | input | NCORE | Per-core store valid |
| st_addr_i | input | NCORE*AW | Per-core store address |
| st_data_i | input | NCORE*DW | Per-core store data |
| st_ready_o | output | NCORE | Per-core store ready |
| sync_req_i | input | NCORE | Per-core sync request pulse |
| sync_done_o | output | NCORE | Per-core one-cycle sync completion |
| sync_gnt_o | output | NCORE | Global sync arbiter grant, one-hot or zero |
| bank_busy_i | input | NBANK | Memory bank busy flags, shared by all cores |
| mem_req_o | output | NCORE | Per-core memory write request |
| mem_addr_o | output | NCORE*AW | Per-core memory write address |
| mem_data_o | output | NCORE*DW | Per-core memory write data |
| mem_ack_i | input | NCORE | Per-core memory write acknowledge |

## Verification
Bank stall masks are applied to buffers loaded with one store per bank. The order of the first two writes then separates lowest-eligible-slot issue from plain arrival order. A same-address pair is placed with the younger store in the lower slot, so an implementation that ignores age shows up as a wrong final value. Syncs are issued against stalled banks, with a post-sync store aimed at a free bank, and with repeated requests, so that drain, epoch ordering and single completion are each isolated. A long run then drives both cores together under random acks and bank stalls. Every write carries its epoch in its data, which checks epoch ordering, rotating grant order and final memory contents all at once.

// File: rtl/wsb_pkg.sv
`timescale 1ns/1ps
package wsb_pkg;
  typedef enum logic [1:0] {
    SY_IDLE,
    SY_DRAIN,
    SY_ARB,
    SY_DONE
  } sync_st_e;
endpackage

// File: rtl/wsb_pick.sv
`timescale 1ns/1ps
// Chooses the lowest-index entry that may write now.
module wsb_pick #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int NBANK = 4
) (
  input  logic [DEPTH-1:0]            vld_i,
  input  logic [DEPTH-1:0][AW-1:0]    addr_i,
  input  logic [DEPTH-1:0][DEPTH-1:0] older_i,
  input  logic [NBANK-1:0]            bank_busy_i,
  output logic                        hit_o,
  output logic [$clog2(DEPTH)-1:0]    idx_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int BW = $clog2(NBANK);

  logic [DEPTH-1:0] elig;

  for (genvar i = 0; i < DEPTH; i++) begin : g_elig
    logic [DEPTH-1:0] same_old;
    for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
      assign same_old[j] = vld_i[j] && older_i[i][j] && (addr_i[j] == addr_i[i]);
    end
    assign elig[i] = vld_i[i] && !bank_busy_i[addr_i[i][BW-1:0]] && (same_old == '0);
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wsb_sync_arb.sv
`timescale 1ns/1ps
module wsb_sync_arb #(
  parameter int NCORE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCORE-1:0] req_i,
  output logic [NCORE-1:0] gnt_o
);
  localparam int PW = (NCORE > 1) ? $clog2(NCORE) : 1;

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] gnt_idx;

  always_comb begin
    gnt_o   = '0;
    gnt_idx = '0;
    for (int o = NCORE - 1; o >= 0; o--) begin
      int k;
      k = (int'(ptr_q) + o) % NCORE;
      if (req_i[k]) begin
        gnt_o   = '0;
        gnt_o[k] = 1'b1;
        gnt_idx = PW'(k);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (gnt_o != '0)
      ptr_q <= (int'(gnt_idx) == NCORE - 1) ? '0 : gnt_idx + 1'b1;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R8
  AST_GNT_ONLY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0); // R8
endmodule

// File: rtl/wsb_core_buf.sv
`timescale 1ns/1ps
module wsb_core_buf
  import wsb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int NBANK = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             st_valid_i,
  input  logic [AW-1:0]    st_addr_i,
  input  logic [DW-1:0]    st_data_i,
  output logic             st_ready_o,
  input  logic             sync_req_i,
  output logic             sync_done_o,
  input  logic [NBANK-1:0] bank_busy_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_data_o,
  input  logic             mem_ack_i,
  output logic             arb_req_o,
  input  logic             arb_gnt_i
);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0]            vld_q;
  logic [DEPTH-1:0][AW-1:0]    addr_q;
  logic [DEPTH-1:0][DW-1:0]    data_q;
  logic [DEPTH-1:0][DEPTH-1:0] older_q; // older_q[i][j]: j was accepted before i
  logic                        iss_vld_q;
  logic [AW-1:0]               iss_addr_q;
  logic [DW-1:0]               iss_data_q;
  sync_st_e                    st_q, st_d;

  logic          pick_hit, enq, iss_load, drained;
  logic [IW-1:0] pick_idx, free_idx;

  wsb_pick #(.DEPTH(DEPTH), .AW(AW), .NBANK(NBANK)) u_pick (
    .vld_i      (vld_q),
    .addr_i     (addr_q),
    .older_i    (older_q),
    .bank_busy_i(bank_busy_i),
    .hit_o      (pick_hit),
    .idx_o      (pick_idx)
  );

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld_q[i]) free_idx = IW'(i);
  end

  assign st_ready_o = !(&vld_q) && (st_q == SY_IDLE);
  assign enq        = st_valid_i && st_ready_o;
  assign iss_load   = !iss_vld_q && pick_hit;
  assign drained    = (vld_q == '0) && !iss_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q     <= '0;
      iss_vld_q <= 1'b0;
    end else begin
      if (iss_load) vld_q[pick_idx] <= 1'b0;
      if (enq)      vld_q[free_idx] <= 1'b1;
      if (iss_load)                    iss_vld_q <= 1'b1;
      else if (iss_vld_q && mem_ack_i) iss_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (enq) begin
      addr_q[free_idx] <= st_addr_i;
      data_q[free_idx] <= st_data_i;
      for (int i = 0; i < DEPTH; i++) older_q[i][free_idx] <= 1'b0;
      older_q[free_idx] <= vld_q;
    end
    if (iss_load) begin
      iss_addr_q <= addr_q[pick_idx];
      iss_data_q <= data_q[pick_idx];
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SY_IDLE:  if (sync_req_i) st_d = SY_DRAIN;
      SY_DRAIN: if (drained)    st_d = SY_ARB;
      SY_ARB:   if (arb_gnt_i)  st_d = SY_DONE;
      SY_DONE:                  st_d = SY_IDLE;
      default:                  st_d = SY_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SY_IDLE;
    else         st_q <= st_d;
  end

  assign sync_done_o = (st_q == SY_DONE);
  assign arb_req_o   = (st_q == SY_ARB);
  assign mem_req_o   = iss_vld_q;
  assign mem_addr_o  = iss_addr_q;
  assign mem_data_o  = iss_data_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o)); // R5
  AST_DONE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_done_o |-> (vld_q == '0) && !mem_req_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_done_o |=> !sync_done_o); // R9
  AST_DONE_AFTER_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_req_o && arb_gnt_i |=> sync_done_o); // R8
endmodule

// File: rtl/wsb_store_sys.sv
`timescale 1ns/1ps
module wsb_store_sys #(
  parameter int NCORE = 2,
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int NBANK = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NCORE-1:0]    st_valid_i,
  input  logic [NCORE*AW-1:0] st_addr_i,
  input  logic [NCORE*DW-1:0] st_data_i,
  output logic [NCORE-1:0]    st_ready_o,
  input  logic [NCORE-1:0]    sync_req_i,
  output logic [NCORE-1:0]    sync_done_o,
  output logic [NCORE-1:0]    sync_gnt_o,
  input  logic [NBANK-1:0]    bank_busy_i,
  output logic [NCORE-1:0]    mem_req_o,
  output logic [NCORE*AW-1:0] mem_addr_o,
  output logic [NCORE*DW-1:0] mem_data_o,
  input  logic [NCORE-1:0]    mem_ack_i
);
  logic [NCORE-1:0] arb_req;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    wsb_core_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .NBANK(NBANK)) u_buf (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .st_valid_i (st_valid_i[c]),
      .st_addr_i  (st_addr_i[c*AW +: AW]),
      .st_data_i  (st_data_i[c*DW +: DW]),
      .st_ready_o (st_ready_o[c]),
      .sync_req_i (sync_req_i[c]),
      .sync_done_o(sync_done_o[c]),
      .bank_busy_i(bank_busy_i),
      .mem_req_o  (mem_req_o[c]),
      .mem_addr_o (mem_addr_o[c*AW +: AW]),
      .mem_data_o (mem_data_o[c*DW +: DW]),
      .mem_ack_i  (mem_ack_i[c]),
      .arb_req_o  (arb_req[c]),
      .arb_gnt_i  (sync_gnt_o[c])
    );
  end

  wsb_sync_arb #(.NCORE(NCORE)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (arb_req),
    .gnt_o (sync_gnt_o)
  );
endmodule

// File: tb/wsb_store_sys_bench.sv
`timescale 1ns/1ps
module wsb_store_sys_bench;
  localparam int NC = 2, DEPTH = 8, AW = 8, DW = 16, NB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NC-1:0]    st_valid = '0, sync_req = '0, mem_ack = '0;
  logic [NC*AW-1:0] st_addr = '0;
  logic [NC*DW-1:0] st_data = '0;
  logic [NB-1:0]    bank_busy = '0;
  logic [NC-1:0]    st_ready, sync_done, sync_gnt, mem_req;
  logic [NC*AW-1:0] mem_addr;
  logic [NC*DW-1:0] mem_data;

  wsb_store_sys #(.NCORE(NC), .DEPTH(DEPTH), .AW(AW), .DW(DW), .NBANK(NB)) u_wsb_store_sys (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data), .st_ready_o(st_ready),
    .sync_req_i(sync_req), .sync_done_o(sync_done), .sync_gnt_o(sync_gnt),
    .bank_busy_i(bank_busy),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_ack_i(mem_ack)
  );

  int nvec = 0, nfail = 0, cyc = 0;
  logic [AW-1:0] wr_a [NC][1024];
  logic [DW-1:0] wr_d [NC][1024];
  int wr_cnt [NC], pushed [NC], done_cnt [NC];
  logic [DW-1:0] mem_model [256], exp_mem [256];
  bit   touched [256];
  logic [7:0] ep [NC], last_ep [NC];
  int ack_mode = 0;
  bit ep_chk = 0, busy_rand = 0;
  int glog [256];
  int gcnt = 0;
  logic [NC-1:0] prev_gnt = '0;

  function automatic logic [31:0] xs(logic [31:0] s);
    s ^= s << 13; s ^= s >> 17; s ^= s << 5;
    return s;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  task automatic record(int c);
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    a = mem_addr[c*AW +: AW];
    d = mem_data[c*DW +: DW];
    wr_a[c][wr_cnt[c]] = a;
    wr_d[c][wr_cnt[c]] = d;
    wr_cnt[c]++;
    mem_model[a] = d;
    if (ep_chk) begin
      chk(d[15:8] >= last_ep[c], "R7 epoch went backwards", d[15:8], last_ep[c]);
      last_ep[c] = d[15:8];
    end
  endtask

  task automatic ack_drv(int c);
    logic [31:0] s;
    s = 32'h1234_5678 + c;
    forever begin
      @(negedge clk);
      s = xs(s);
      mem_ack[c] = (ack_mode == 0) ? 1'b1 : (ack_mode == 1) ? (s[0] | s[3]) : 1'b0;
      if (mem_req[c] && mem_ack[c]) record(c);
    end
  endtask

  task automatic push(int c, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    st_valid[c] = 1'b1;
    st_addr[c*AW +: AW] = a;
    st_data[c*DW +: DW] = d;
    #1;
    while (!st_ready[c]) begin
      @(negedge clk); #1;
    end
    pushed[c]++;
    exp_mem[a] = d;
    touched[a] = 1'b1;
    @(posedge clk); #1;
    st_valid[c] = 1'b0;
  endtask

  task automatic wait_wr(int c, int n);
    while (wr_cnt[c] < n) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic do_sync(int c, bit chk_rdy);
    int snap;
    @(negedge clk);
    sync_req[c] = 1'b1;
    snap = pushed[c];
    ep[c]++;
    @(posedge clk); #1;
    sync_req[c] = 1'b0;
    @(negedge clk); #1;
    if (chk_rdy) chk(!st_ready[c], "R6 ready during sync", st_ready[c], 0);
    while (!sync_done[c]) begin
      @(negedge clk); #1;
    end
    chk(wr_cnt[c] == snap, "R6 pre-sync writes done", wr_cnt[c], snap);
  endtask

  task automatic sweep(int c);
    logic [31:0] s;
    s = 32'hace1_0000 + c;
    for (int i = 0; i < 200; i++) begin
      s = xs(s);
      if (i % 20 == 19) do_sync(c, 1'b0);
      if (s[9]) @(negedge clk);
      push(c, {c[0], s[6:0]}, {ep[c], i[7:0]});
    end
  endtask

  // monitor and watchdog
  initial begin
    forever begin
      @(negedge clk); #1;
      cyc++;
      for (int c = 0; c < NC; c++)
        if (sync_done[c]) begin
          done_cnt[c]++;
          chk(prev_gnt[c], "R8 done one cycle after grant", prev_gnt, 1 << c);
        end
      if (sync_gnt != '0) begin
        glog[gcnt] = sync_gnt[1] ? 1 : 0;
        gcnt++;
      end
      prev_gnt = sync_gnt;
      if (cyc > 150000) begin
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        summary();
      end
    end
  end

  initial begin
    logic [31:0] s;
    s = 32'h0bad_cafe;
    forever begin
      @(negedge clk);
      s = xs(s);
      if (busy_rand) bank_busy = s[3:0] & s[7:4];
    end
  end

  initial begin
    int base, gc, d0;
    for (int c = 0; c < NC; c++) begin
      wr_cnt[c] = 0; pushed[c] = 0; done_cnt[c] = 0; ep[c] = '0; last_ep[c] = '0;
    end
    for (int a = 0; a < 256; a++) begin
      touched[a] = 1'b0; mem_model[a] = '0; exp_mem[a] = '0;
    end
    fork
      ack_drv(0);
      ack_drv(1);
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(st_ready == '1, "R1 ready", st_ready, 3);
    chk(mem_req == '0, "R1 mem_req", mem_req, 0);
    chk(sync_done == '0, "R1 sync_done", sync_done, 0);
    chk(sync_gnt == '0, "R1 grant", sync_gnt, 0);

    // R3 bypass of a stalled bank, lowest eligible slot first
    bank_busy = '1;
    push(0, 8'h10, 16'h0a10); push(0, 8'h11, 16'h0a11);
    push(0, 8'h12, 16'h0a12); push(0, 8'h13, 16'h0a13);
    base = wr_cnt[0];
    bank_busy = 4'b0001;
    wait_wr(0, base + 1);
    chk(wr_a[0][base] == 8'h11, "R3 bypass first write", wr_a[0][base], 8'h11);
    bank_busy = '0;
    wait_wr(0, base + 4);
    chk(wr_a[0][base+1] == 8'h10, "R3 lowest slot second", wr_a[0][base+1], 8'h10);
    chk(wr_a[0][base+2] == 8'h12, "R3 third", wr_a[0][base+2], 8'h12);
    chk(wr_a[0][base+3] == 8'h13, "R3 fourth", wr_a[0][base+3], 8'h13);

    // R4 same address, younger store sits in the lower slot
    bank_busy = '1;
    push(0, 8'h30, 16'h3030);
    push(0, 8'h21, 16'haaaa);
    base = wr_cnt[0];
    bank_busy = 4'b1110;
    wait_wr(0, base + 1);
    bank_busy = '1;
    chk(wr_a[0][base] == 8'h30, "R4 setup write", wr_a[0][base], 8'h30);
    push(0, 8'h21, 16'hcccc);
    bank_busy = '0;
    wait_wr(0, base + 3);
    chk(wr_d[0][base+1] == 16'haaaa, "R4 older first", wr_d[0][base+1], 16'haaaa);
    chk(wr_d[0][base+2] == 16'hcccc, "R4 younger second", wr_d[0][base+2], 16'hcccc);
    chk(mem_model[8'h21] == 16'hcccc, "R4 final value", mem_model[8'h21], 16'hcccc);

    // R2 capacity
    bank_busy = '1;
    base = wr_cnt[0];
    for (int i = 0; i < 8; i++) push(0, 8'h40 + 8'(i), 16'h4000 + 16'(i));
    @(negedge clk); #1;
    chk(!st_ready[0], "R2 full drops ready", st_ready[0], 0);
    chk(st_ready[1], "R2 other core ready", st_ready[1], 1);
    bank_busy = '0;
    wait_wr(0, base + 8);
    chk(st_ready[0], "R2 ready after drain", st_ready[0], 1);

    // R5 request held until ack, one outstanding
    ack_mode = 2;
    push(0, 8'h55, 16'hbeef);
    push(0, 8'h56, 16'hf00d);
    repeat (2) @(negedge clk); #1;
    chk(mem_req[0] && mem_addr[7:0] == 8'h55, "R5 request up", mem_addr[7:0], 8'h55);
    repeat (3) @(negedge clk); #1;
    chk(mem_req[0] && mem_addr[7:0] == 8'h55 && mem_data[15:0] == 16'hbeef,
        "R5 held stable", mem_data[15:0], 16'hbeef);
    ack_mode = 0;
    base = wr_cnt[0];
    wait_wr(0, base + 2);

    // R6 sync drains stalled stores
    bank_busy = '1;
    push(0, 8'h60, 16'h6060); push(0, 8'h61, 16'h6161); push(0, 8'h62, 16'h6262);
    fork
      do_sync(0, 1'b1);
      begin repeat (4) @(negedge clk); bank_busy = '0; end
    join

    // R7 post-sync store to a free bank waits behind a stalled pre-sync store
    bank_busy = 4'b0001;
    base = wr_cnt[0];
    push(0, 8'h70, 16'h7070);
    fork
      do_sync(0, 1'b0);
      begin repeat (2) @(negedge clk); push(0, 8'h71, 16'h7171); end
      begin repeat (6) @(negedge clk); bank_busy = '0; end
    join
    wait_wr(0, base + 2);
    chk(wr_a[0][base] == 8'h70, "R7 pre-sync first", wr_a[0][base], 8'h70);
    chk(wr_a[0][base+1] == 8'h71, "R7 post-sync second", wr_a[0][base+1], 8'h71);

    // R9 second request during a sync is ignored
    bank_busy = '1;
    push(0, 8'h0f, 16'h0f0f);
    d0 = done_cnt[0];
    fork
      do_sync(0, 1'b0);
      begin
        repeat (3) @(negedge clk);
        sync_req[0] = 1'b1;
        @(posedge clk); #1;
        sync_req[0] = 1'b0;
        repeat (2) @(negedge clk);
        bank_busy = '0;
      end
    join
    repeat (8) @(negedge clk);
    chk(done_cnt[0] - d0 == 1, "R9 one done per sync", done_cnt[0] - d0, 1);

    // R8 rotation between simultaneous syncs
    do_sync(1, 1'b0);
    gc = gcnt;
    fork do_sync(0, 1'b0); do_sync(1, 1'b0); join
    chk(glog[gc] == 0 && glog[gc+1] == 1, "R8 order after core1", glog[gc], 0);
    do_sync(0, 1'b0);
    gc = gcnt;
    fork do_sync(0, 1'b0); do_sync(1, 1'b0); join
    chk(glog[gc] == 1 && glog[gc+1] == 0, "R8 order after core0", glog[gc], 1);

    // R7 R4 R8 concurrent sweep under random stalls
    for (int c = 0; c < NC; c++) last_ep[c] = ep[c];
    ep_chk = 1'b1; ack_mode = 1; busy_rand = 1'b1;
    fork sweep(0); sweep(1); join
    busy_rand = 1'b0; bank_busy = '0; ack_mode = 0;
    wait_wr(0, pushed[0]);
    wait_wr(1, pushed[1]);
    repeat (4) @(negedge clk); #1;
    for (int c = 0; c < NC; c++)
      chk(wr_cnt[c] == pushed[c], "R7 all stores written", wr_cnt[c], pushed[c]);
    for (int a = 0; a < 256; a++)
      if (touched[a]) chk(mem_model[a] == exp_mem[a], "R4 final memory", mem_model[a], exp_mem[a]);
    summary();
  end
endmodule